// File: doc/BRIEF.md
# CAN Error Status Capture Register

This block keeps a 3-bit error code for a CAN controller and signals a host processor when a new error is recorded. Every clock cycle it samples six error-event strobes from the bus logic. If more than one strobe is high in the same cycle, a fixed priority picks one code. Once a code is recorded, it stays in place and later errors are dropped until the host reads the status register.

A host read returns the code that is currently held. The field then moves to a sentinel value, 111, which means "no change since the last read". The sentinel stays until the controller finishes a frame or reports a new error. A frame-done strobe with no error clears the field to 000. The interrupt request is a level. It rises when an error is recorded and drops when the host reads. The host write port exists, but a write has no effect on the code or on the interrupt.

Top module: `errcap_status`

## Requirements
- R1: Strobe bit i of `errStrobe` records code i+1: bit 0 stuff (001), bit 1 format (010), bit 2 transmit not acknowledged (011), bit 3 bit-1 error (100), bit 4 bit-0 error (101), bit 5 CRC (110). 000 means no error in the last frame and 111 is the sentinel.
- R2: When several strobes are high in one cycle, the code recorded follows this priority, highest first: bit-0 error, stuff, CRC, transmit not acknowledged, format, bit-1 error.
- R3: A cycle with `hostRd` high sets `errCode` to 111 on the next cycle. `irq` drops at that same edge.
- R4: 111 is held while no error and no frame-done strobe arrive. A frame-done strobe with no error, while the field holds 000 or 111, sets the field to 000.
- R5: An error is recorded only while the field holds 000 or 111. Errors and frame-done strobes that arrive while another code is held are discarded, and the held code is kept.
- R6: `irq` rises in the same cycle that the field changes from 000 or 111 to an error code. It stays high until a host read.
- R7: `hostWr` and `hostWrData` change neither `errCode` nor `irq`.
- R8: After reset, `errCode` is 000 and `irq` is low.
- R9: If a read and an error arrive in the same cycle, the read wins and the field goes to 111. The error is recorded on the next cycle only if it is still presented then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| errStrobe | input | 6 | Error-event strobes, one bit per error type |
| frameDone | input | 1 | Strobe: a frame was transmitted or received |
| hostRd | input | 1 | Strobe: the host reads the status register |
| hostWr | input | 1 | Strobe: the host writes the status register |
| hostWrData | input | DATA_W | Host write data (discarded) |
| errCode | output | 3 | Current error code field |
| irq | output | 1 | Interrupt request level |

## Verification
The bench builds the block with DATA_W set to 16 instead of the default 8. This lets wide, nonzero write words reach the discarded write path, so they can be shown to leave the code and the interrupt unchanged. The directed tests cover every single strobe and several multi-strobe masks chosen so that each priority level wins at least once. They also cover the held-code and sentinel windows, and the case where a read and an error land in the same cycle.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
  localparam int CODE_W  = 3;
  localparam int NUM_SRC = 6;

  typedef enum logic [CODE_W-1:0] {
    CODE_NONE   = 3'b000,
    CODE_STUFF  = 3'b001,
    CODE_FORMAT = 3'b010,
    CODE_NOACK  = 3'b011,
    CODE_BIT1   = 3'b100,
    CODE_BIT0   = 3'b101,
    CODE_CRC    = 3'b110,
    CODE_SENT   = 3'b111
  } errCode_e;

  // Commands from the control module to the datapath.
  typedef struct packed {
    logic takeErr;    // record the selected error code
    logic markRead;   // host read: move the field to the sentinel
    logic markClean;  // frame finished without an error: field to none
  } fieldCmd_t;

  // Rank of each strobe source (1 = most urgent), indexed by strobe bit.
  localparam int SRC_RANK [NUM_SRC] = '{2, 5, 4, 6, 1, 3};
endpackage

// File: rtl/errcap_data.sv
module errcap_data
  import errcap_pkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NSRC-1:0]     errStrobe,
  input  fieldCmd_t           cmd,
  output logic [CODE_W-1:0]   errCode,
  output logic                anyErr,
  output logic                fieldOpen
);
  localparam int RANK_W = $clog2(NSRC + 1);

  logic [CODE_W-1:0] pickCode;
  logic [NSRC-1:0][RANK_W-1:0] srcRank;

  // Each active source carries its rank; an inactive one carries zero.
  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : gRank
      assign srcRank[g] = errStrobe[g] ? RANK_W'(SRC_RANK[g]) : '0;
    end
  endgenerate

  // Choose the active source with the smallest nonzero rank.
  always_comb begin
    logic [RANK_W-1:0] bestRank;
    pickCode = CODE_NONE;
    bestRank = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (srcRank[i] != '0 && srcRank[i] < bestRank) begin
        bestRank = srcRank[i];
        pickCode = CODE_W'(i + 1);
      end
    end
  end

  assign anyErr    = |errStrobe;
  assign fieldOpen = (errCode == CODE_NONE) || (errCode == CODE_SENT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCode <= CODE_NONE;
    end else if (cmd.markRead) begin
      errCode <= CODE_SENT;
    end else if (cmd.takeErr) begin
      errCode <= pickCode;
    end else if (cmd.markClean) begin
      errCode <= CODE_NONE;
    end
  end
endmodule

// File: rtl/errcap_ctrl.sv
module errcap_ctrl
  import errcap_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostRd,
  input  logic      frameDone,
  input  logic      anyErr,
  input  logic      fieldOpen,
  output fieldCmd_t cmd,
  output logic      irq
);
  // A read always wins. Capture and clean happen only while the field is open.
  always_comb begin
    cmd = '0;
    if (hostRd) begin
      cmd.markRead = 1'b1;
    end else if (fieldOpen && anyErr) begin
      cmd.takeErr = 1'b1;
    end else if (fieldOpen && frameDone) begin
      cmd.markClean = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else if (cmd.markRead) begin
      irq <= 1'b0;
    end else if (cmd.takeErr) begin
      irq <= 1'b1;
    end
  end
endmodule

// File: rtl/errcap_status.sv
module errcap_status
  import errcap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [5:0]        errStrobe,
  input  logic              frameDone,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [2:0]        errCode,
  output logic              irq
);
  fieldCmd_t cmd;
  logic      anyErr;
  logic      fieldOpen;

  // The field is read-only: host writes are accepted and dropped.
  logic unusedWrite;
  assign unusedWrite = ^{hostWr, hostWrData};

  errcap_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostRd    (hostRd),
    .frameDone (frameDone),
    .anyErr    (anyErr),
    .fieldOpen (fieldOpen),
    .cmd       (cmd),
    .irq       (irq)
  );

  errcap_data #(.NSRC(NUM_SRC)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .errStrobe (errStrobe),
    .cmd       (cmd),
    .errCode   (errCode),
    .anyErr    (anyErr),
    .fieldOpen (fieldOpen)
  );
endmodule

// File: rtl/errcap_check.sv
module errcap_check (
  input logic       clk,
  input logic       rstN,
  input logic [5:0] errStrobe,
  input logic       frameDone,
  input logic       hostRd,
  input logic       hostWr,
  input logic [2:0] errCode,
  input logic       irq
);
  logic isOpen;
  assign isOpen = (errCode == 3'b000) || (errCode == 3'b111);

  p_read_sentinel_r3: assert property (@(posedge clk) disable iff (!rstN)
    hostRd |=> (errCode == 3'b111) && !irq);

  p_sentinel_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (errCode == 3'b111) && !hostRd && !frameDone && (errStrobe == '0)
      |=> errCode == 3'b111);

  p_held_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    !isOpen && !hostRd |=> $stable(errCode) && irq);

  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (errCode != 3'b000) && (errCode != 3'b111));

  p_bit0_wins_r2: assert property (@(posedge clk) disable iff (!rstN)
    isOpen && !hostRd && errStrobe[4] |=> errCode == 3'b101);

  p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    hostWr && !hostRd && !frameDone && (errStrobe == '0)
      |=> $stable(errCode) && $stable(irq));
endmodule

bind errcap_status errcap_check uChk (
  .clk       (clk),
  .rstN      (rstN),
  .errStrobe (errStrobe),
  .frameDone (frameDone),
  .hostRd    (hostRd),
  .hostWr    (hostWr),
  .errCode   (errCode),
  .irq       (irq)
);

// File: tb/errcap_status_test.sv
module errcap_status_test;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [5:0]    errStrobe = '0;
  logic          frameDone = 1'b0;
  logic          hostRd = 1'b0;
  logic          hostWr = 1'b0;
  logic [DW-1:0] hostWrData = '0;
  logic [2:0]    errCode;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  errcap_status #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .errStrobe(errStrobe), .frameDone(frameDone),
    .hostRd(hostRd), .hostWr(hostWr), .hostWrData(hostWrData),
    .errCode(errCode), .irq(irq)
  );

  // Expected code for a strobe mask, from the R2 priority list.
  function automatic logic [2:0] expCode(input logic [5:0] m);
    int order [6] = '{4, 0, 5, 2, 1, 3};
    for (int k = 0; k < 6; k++)
      if (m[order[k]]) return 3'(order[k] + 1);
    return 3'b000;
  endfunction

  task automatic check(input string req, input logic [2:0] c, input logic q);
    total++;
    if (errCode !== c || irq !== q) begin
      bad++;
      $display("FAIL %s: errCode=%b irq=%b expected errCode=%b irq=%b",
               req, errCode, irq, c, q);
    end
  endtask

  // Inputs change at the falling edge; outputs are checked one falling edge later.
  task automatic cyc(input logic [5:0] e, input logic fd, input logic rd);
    errStrobe = e; frameDone = fd; hostRd = rd;
    @(negedge clk);
    errStrobe = '0; frameDone = 1'b0; hostRd = 1'b0;
  endtask

  task automatic t_reset;
    check("R8", 3'b000, 1'b0);
  endtask

  task automatic t_singles;
    for (int i = 0; i < 6; i++) begin
      cyc(6'(1 << i), 1'b0, 1'b0);
      check("R1", 3'(i + 1), 1'b1);
      cyc('0, 1'b0, 1'b1);
      check("R3", 3'b111, 1'b0);
    end
  endtask

  task automatic t_priority;
    logic [5:0] masks [6] = '{6'h3F, 6'h2F, 6'h2E, 6'h0E, 6'h0A, 6'h08};
    for (int k = 0; k < 6; k++) begin
      cyc(masks[k], 1'b0, 1'b0);
      check("R2", expCode(masks[k]), 1'b1);
      cyc('0, 1'b0, 1'b1);
    end
  endtask

  task automatic t_hold;
    cyc(6'h01, 1'b0, 1'b0);
    check("R6", 3'b001, 1'b1);
    cyc(6'h30, 1'b0, 1'b0);
    check("R5", 3'b001, 1'b1);
    cyc('0, 1'b1, 1'b0);
    check("R5", 3'b001, 1'b1);
    cyc('0, 1'b0, 1'b0);
    check("R6", 3'b001, 1'b1);
    cyc('0, 1'b0, 1'b1);
    check("R3", 3'b111, 1'b0);
  endtask

  task automatic t_sentinel;
    for (int i = 0; i < 3; i++) cyc('0, 1'b0, 1'b0);
    check("R4", 3'b111, 1'b0);
    cyc('0, 1'b1, 1'b0);
    check("R4", 3'b000, 1'b0);
    cyc('0, 1'b0, 1'b1);
    check("R3", 3'b111, 1'b0);
    cyc(6'h20, 1'b1, 1'b0);
    check("R5", 3'b110, 1'b1);
    cyc('0, 1'b0, 1'b1);
    cyc('0, 1'b1, 1'b0);
  endtask

  task automatic t_write;
    hostWr = 1'b1; hostWrData = 16'hFFFF;
    @(negedge clk);
    hostWr = 1'b0;
    check("R7", 3'b000, 1'b0);
    cyc(6'h04, 1'b0, 1'b0);
    hostWr = 1'b1; hostWrData = 16'h0005;
    @(negedge clk);
    hostWr = 1'b1; hostWrData = 16'hA5A7;
    @(negedge clk);
    hostWr = 1'b0;
    check("R7", 3'b011, 1'b1);
    cyc('0, 1'b0, 1'b1);
  endtask

  task automatic t_race;
    cyc(6'h02, 1'b0, 1'b0);
    cyc(6'h10, 1'b0, 1'b1);
    check("R9", 3'b111, 1'b0);
    cyc('0, 1'b0, 1'b0);
    check("R9", 3'b111, 1'b0);
    cyc(6'h08, 1'b0, 1'b1);
    check("R9", 3'b111, 1'b0);
    cyc(6'h08, 1'b0, 1'b0);
    check("R9", 3'b100, 1'b1);
    cyc('0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_singles;
    t_priority;
    t_hold;
    t_sentinel;
    t_write;
    t_race;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule